// File: doc/BRIEF.md
# Power-Button Event Status and Reset-Scope Register Block

This block is a small power-management register file on a plain read/write register bus. It watches a power-button input that has already been debounced and synchronized (low means pressed). Each press is recorded in three separate write-1-to-clear flags:

- a general button flag;
- a copy routed to the SCI request path;
- a copy routed to the SMI request path.

Because each copy is cleared on its own, one consumer acknowledging its flag does not hide the press from the other consumers.

The block also has a software-fired "notify now" flag. Writing a trigger bit in the control register sets this flag, and it can raise an SCI. The flag re-arms after software clears it.

A one-bit reset-scope policy decides what a reset-port write asks for. A write of 06h or 0Eh produces a single-cycle pulse on either the host-only reset request or the global (host plus management) reset request.

Top module: `pwrbtn_evt_regs`

Register map. The bus address is 3 bits and each register is 32 bits.

| Address | Register | Implemented bits |
|---|---|---|
| 0 | policy | bit 0 = global scope |
| 1 | event status | bit 0 = notify-now flag, bit 1 = SCI button copy, bit 2 = SMI button copy |
| 2 | control | bit 0 = trigger (write-only, reads 0), bit 1 = enable notify-now SCI, bit 2 = enable button SCI, bit 3 = enable button SMI |
| 3 | reset port | write-only, reads 0 |
| 4 | general button status | bit 0 |

Writes take effect on the clock edge where `bus_we` is high. Reads are combinational from the registered state.

## Requirements
- R1: A high-to-low change of `pwrbtn_n` between two consecutive clock edges sets status bits 1 and 2 and general bit 0, visible after the second edge. A rising change or a steady level sets nothing.
- R2: A flag clears only when 1 is written to its own bit position. Writing 0 leaves it unchanged.
- R3: Clearing the general button bit leaves both routed copies set. Clearing one routed copy leaves the other one set.
- R4: Writing 1 to control bit 0 sets status bit 0 after that edge. Control bit 0 always reads 0.
- R5: Status bit 0 holds through further writes until 1 is written to it. After that clear, the next trigger write sets it again.
- R6: `sci_req` is high exactly when (status bit 0 AND control bit 1) OR (status bit 1 AND control bit 2). `smi_req` is high exactly when status bit 2 AND control bit 3.
- R7: When a set event and a write-1-to-clear hit the same flag on the same edge, the flag ends set.
- R8: A reset-port write with `bus_wdata[7:0]` equal to 06h or 0Eh gives a one-cycle pulse in the cycle after the write edge. The pulse is on `global_rst_pulse` if policy bit 0 is 1, and on `host_rst_pulse` if it is 0.
- R9: A reset-port write with any other low byte gives no pulse on either output.
- R10: After reset, every register reads 0, both requests are low and neither reset pulse is active.
- R11: Reserved bits read 0 and ignore writes, including every bit of the reset port and of unused addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrbtn_n | input | 1 | Debounced, synchronized button level, low = pressed |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sci_req | output | 1 | SCI request level |
| smi_req | output | 1 | SMI request level |
| host_rst_pulse | output | 1 | One-cycle host-only reset request |
| global_rst_pulse | output | 1 | One-cycle global reset request |

## Verification
The hardest case to reach is a button falling edge that lands on the same clock edge as a write-1-to-clear of one routed copy. The bench drives the button low and the clearing write within the same half-cycle, so the detector and the bus decode act together on one edge. It then reads back that the copy is still set and that its sibling is unaffected. A behavioural reference model follows every edge and checks the requests, the reset pulses and the addressed read data on each cycle. This also covers re-arming of the notify flag and both policy settings on the reset port.

// File: rtl/pbreg_pkg.sv
package pbreg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    // register addresses
    localparam int ADDR_POLICY  = 0;
    localparam int ADDR_STATUS  = 1;
    localparam int ADDR_CTRL    = 2;
    localparam int ADDR_RSTPORT = 3;
    localparam int ADDR_GENSTS  = 4;

    // status bit positions; index 3 is the general flag held in the same bank
    localparam int ST_NOW  = 0;
    localparam int ST_BSCI = 1;
    localparam int ST_BSMI = 2;
    localparam int ST_GEN  = 3;
    localparam int NUM_FLAGS = 4;

    // control bit positions
    localparam int CT_FIRE    = 0;
    localparam int CT_EN_NOW  = 1;
    localparam int CT_EN_BSCI = 2;
    localparam int CT_EN_BSMI = 3;
    localparam int NUM_EN     = 3;

    localparam int POL_GLOBAL = 0;

    localparam logic [7:0] RSTCODE_WARM = 8'h06;
    localparam logic [7:0] RSTCODE_COLD = 8'h0E;

    typedef struct packed {
        logic host;
        logic glob;
    } rst_req_t;
endpackage

// File: rtl/pbreg_edge.sv
module pbreg_edge #(
    parameter bit IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n,
    output logic fall
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_n;
        fall      = st_q.prev & ~lvl_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: IDLE_LVL};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pbreg_w1c_bank.sv
module pbreg_w1c_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_ev,
    output logic [N-1:0] flags
);
    logic [N-1:0] flag_d, flag_q;

    // a set on the same edge as a clear wins, so no event is lost
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            flag_d[i] = set_ev[i] | (flag_q[i] & ~clr_ev[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;
endmodule

// File: rtl/pbreg_rstport.sv
module pbreg_rstport
    import pbreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_wr,
    input  logic [7:0] port_byte,
    input  logic       global_scope,
    output logic       host_pulse,
    output logic       glob_pulse
);
    rst_req_t req_d, req_q;
    logic     code_hit;

    always_comb begin
        code_hit = (port_byte == RSTCODE_WARM) || (port_byte == RSTCODE_COLD);
        req_d    = '0;
        if (port_wr && code_hit) begin
            req_d.glob = global_scope;
            req_d.host = ~global_scope;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign host_pulse = req_q.host;
    assign glob_pulse = req_q.glob;
endmodule

// File: rtl/pwrbtn_evt_regs.sv
module pwrbtn_evt_regs
    import pbreg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwrbtn_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sci_req,
    output logic          smi_req,
    output logic          host_rst_pulse,
    output logic          global_rst_pulse
);
    localparam logic [AW-1:0] A_POL = AW'(ADDR_POLICY);
    localparam logic [AW-1:0] A_STS = AW'(ADDR_STATUS);
    localparam logic [AW-1:0] A_CTL = AW'(ADDR_CTRL);
    localparam logic [AW-1:0] A_RST = AW'(ADDR_RSTPORT);
    localparam logic [AW-1:0] A_GEN = AW'(ADDR_GENSTS);

    typedef struct packed {
        logic              pol_global;
        logic [NUM_EN-1:0] en;   // [0]=now->SCI, [1]=btn->SCI, [2]=btn->SMI
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic                 btn_fall;
    logic [NUM_FLAGS-1:0] set_vec, clr_vec, sts_q;
    logic                 wr_pol, wr_sts, wr_ctl, wr_rst, wr_gen;

    pbreg_edge #(.IDLE_LVL(1'b1)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n (pwrbtn_n),
        .fall  (btn_fall)
    );

    always_comb begin
        wr_pol = bus_we && (bus_addr == A_POL);
        wr_sts = bus_we && (bus_addr == A_STS);
        wr_ctl = bus_we && (bus_addr == A_CTL);
        wr_rst = bus_we && (bus_addr == A_RST);
        wr_gen = bus_we && (bus_addr == A_GEN);

        set_vec          = '0;
        set_vec[ST_NOW]  = wr_ctl && bus_wdata[CT_FIRE];
        set_vec[ST_BSCI] = btn_fall;
        set_vec[ST_BSMI] = btn_fall;
        set_vec[ST_GEN]  = btn_fall;

        clr_vec          = '0;
        clr_vec[ST_NOW]  = wr_sts && bus_wdata[ST_NOW];
        clr_vec[ST_BSCI] = wr_sts && bus_wdata[ST_BSCI];
        clr_vec[ST_BSMI] = wr_sts && bus_wdata[ST_BSMI];
        clr_vec[ST_GEN]  = wr_gen && bus_wdata[0];
    end

    pbreg_w1c_bank #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_vec),
        .clr_ev (clr_vec),
        .flags  (sts_q)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_pol) cfg_d.pol_global = bus_wdata[POL_GLOBAL];
        if (wr_ctl) cfg_d.en = bus_wdata[CT_EN_BSMI:CT_EN_NOW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    pbreg_rstport u_rstport (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_wr      (wr_rst),
        .port_byte    (bus_wdata[7:0]),
        .global_scope (cfg_q.pol_global),
        .host_pulse   (host_rst_pulse),
        .glob_pulse   (global_rst_pulse)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_POL: bus_rdata[POL_GLOBAL] = cfg_q.pol_global;
            A_STS: bus_rdata[ST_BSMI:ST_NOW] = sts_q[ST_BSMI:ST_NOW];
            A_CTL: bus_rdata[CT_EN_BSMI:CT_EN_NOW] = cfg_q.en;
            A_GEN: bus_rdata[0] = sts_q[ST_GEN];
            default: bus_rdata = '0;
        endcase
    end

    assign sci_req = (sts_q[ST_NOW] & cfg_q.en[0]) | (sts_q[ST_BSCI] & cfg_q.en[1]);
    assign smi_req = sts_q[ST_BSMI] & cfg_q.en[2];
endmodule

// File: rtl/pwrbtn_evt_regs_chk.sv
module pwrbtn_evt_regs_chk
    import pbreg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwrbtn_n,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          sci_req,
    input logic          smi_req,
    input logic          host_rst_pulse,
    input logic          global_rst_pulse,
    input logic [3:0]    flags
);
    logic rst_hit, rst_write;
    assign rst_write = bus_we && (bus_addr == AW'(ADDR_RSTPORT));
    assign rst_hit   = rst_write &&
                       ((bus_wdata[7:0] == RSTCODE_WARM) || (bus_wdata[7:0] == RSTCODE_COLD));

    // R1 R7
    btn_fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwrbtn_n) |=> (flags[ST_BSCI] && flags[ST_BSMI] && flags[ST_GEN]));

    // R2
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(ADDR_STATUS) && bus_wdata[ST_BSMI] && !$fell(pwrbtn_n))
        |=> !flags[ST_BSMI]);

    // R4
    fire_sets_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(ADDR_CTRL) && bus_wdata[CT_FIRE]) |=> flags[ST_NOW]);

    // R6
    sci_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_req |-> (flags[ST_NOW] || flags[ST_BSCI]));

    // R6
    smi_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> flags[ST_BSMI]);

    // R8
    pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rst_pulse || global_rst_pulse) |-> $past(rst_hit));

    // R8
    one_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rst_pulse && global_rst_pulse));

    // R9
    bad_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_write && !rst_hit) |=> !(host_rst_pulse || global_rst_pulse));

    // R11
    sts_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(ADDR_STATUS)) |-> (bus_rdata[DW-1:ST_BSMI+1] == '0));
endmodule

bind pwrbtn_evt_regs pwrbtn_evt_regs_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .pwrbtn_n         (pwrbtn_n),
    .bus_we           (bus_we),
    .bus_addr         (bus_addr),
    .bus_wdata        (bus_wdata),
    .bus_rdata        (bus_rdata),
    .sci_req          (sci_req),
    .smi_req          (smi_req),
    .host_rst_pulse   (host_rst_pulse),
    .global_rst_pulse (global_rst_pulse),
    .flags            (sts_q)
);

// File: tb/pwrbtn_evt_regs_test.sv
`timescale 1ns/1ps
module pwrbtn_evt_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrbtn_n = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sci_req, smi_req, host_rst_pulse, global_rst_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    pwrbtn_evt_regs uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .pwrbtn_n         (pwrbtn_n),
        .bus_we           (bus_we),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .sci_req          (sci_req),
        .smi_req          (smi_req),
        .host_rst_pulse   (host_rst_pulse),
        .global_rst_pulse (global_rst_pulse)
    );

    // behavioural reference model
    bit m_prev = 1, m_now, m_bsci, m_bsmi, m_gen, m_pol, m_host, m_glob;
    bit m_en_now, m_en_bsci, m_en_bsmi;

    function automatic logic [31:0] model_read(input logic [2:0] a);
        logic [31:0] r = '0;
        case (a)
            3'd0: r[0] = m_pol;
            3'd1: r[2:0] = {m_bsmi, m_bsci, m_now};
            3'd2: r[3:1] = {m_en_bsmi, m_en_bsci, m_en_now};
            3'd4: r[0] = m_gen;
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 1; m_now = 0; m_bsci = 0; m_bsmi = 0; m_gen = 0;
            m_pol = 0; m_host = 0; m_glob = 0;
            m_en_now = 0; m_en_bsci = 0; m_en_bsmi = 0;
        end else begin
            bit press, hit;
            press = m_prev && !pwrbtn_n;
            m_prev = pwrbtn_n;
            hit = bus_we && bus_addr == 3'd3 &&
                  (bus_wdata[7:0] == 8'h06 || bus_wdata[7:0] == 8'h0E);
            m_host = hit && !m_pol;
            m_glob = hit && m_pol;
            if (bus_we && bus_addr == 3'd1) begin
                if (bus_wdata[0]) m_now = 0;
                if (bus_wdata[1]) m_bsci = 0;
                if (bus_wdata[2]) m_bsmi = 0;
            end
            if (bus_we && bus_addr == 3'd4 && bus_wdata[0]) m_gen = 0;
            if (bus_we && bus_addr == 3'd2) begin
                if (bus_wdata[0]) m_now = 1;
                m_en_now = bus_wdata[1]; m_en_bsci = bus_wdata[2]; m_en_bsmi = bus_wdata[3];
            end
            if (bus_we && bus_addr == 3'd0) m_pol = bus_wdata[0];
            if (press) begin m_bsci = 1; m_bsmi = 1; m_gen = 1; end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R8 policy read";
            3'd1: return "R1/R5/R7 status read";
            3'd2: return "R4 control read";
            3'd4: return "R3 general read";
            default: return "R11 reserved read";
        endcase
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 sci_req", 32'(sci_req),
                  32'((m_now && m_en_now) || (m_bsci && m_en_bsci)));
            check("R6 smi_req", 32'(smi_req), 32'(m_bsmi && m_en_bsmi));
            check("R8 host pulse", 32'(host_rst_pulse), 32'(m_host));
            check("R8 global pulse", 32'(global_rst_pulse), 32'(m_glob));
            check(read_tag(bus_addr), bus_rdata, model_read(bus_addr));
        end
    end

    task automatic drive(input bit we, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_we = we; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        drive(1'b1, a, d);
        drive(1'b0, a, '0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; bus_we = 0; end
    endtask

    task automatic btn(input bit lvl);
        @(negedge clk); #1; pwrbtn_n = lvl;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); #1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        check(req, bus_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R10 reset state
        for (int a = 0; a < 8; a++) rd_expect(3'(a), 32'h0, "R10 reset read");
        check("R10 outputs", {28'h0, sci_req, smi_req, host_rst_pulse, global_rst_pulse}, 32'h0);

        wr(3'd2, 32'h0000_000E);               // all enables on
        btn(0); idle(2);                        // R1 press
        rd_expect(3'd1, 32'h6, "R1 press sets copies");
        rd_expect(3'd4, 32'h1, "R1 press sets general");
        btn(1); idle(2);                        // R1 release sets nothing
        wr(3'd1, 32'h0);                        // R2 zero write no effect
        rd_expect(3'd1, 32'h6, "R2 write zero");
        wr(3'd4, 32'h1);                        // R3 clear general
        rd_expect(3'd1, 32'h6, "R3 copies survive general clear");
        wr(3'd1, 32'h2);                        // R3 clear SCI copy only
        rd_expect(3'd1, 32'h4, "R3 SMI copy survives");
        check("R6 smi only", {30'h0, sci_req, smi_req}, 32'h1);
        wr(3'd1, 32'h4);

        wr(3'd2, 32'h0000_000F);                // R4 fire
        rd_expect(3'd1, 32'h1, "R4 fire sets now");
        rd_expect(3'd2, 32'h0000_000E, "R4 trigger reads 0");
        wr(3'd2, 32'h0000_000F);                // still set
        wr(3'd1, 32'h1);                        // R5 clear
        rd_expect(3'd1, 32'h0, "R5 cleared");
        wr(3'd2, 32'h0000_000F);                // R5 re-arm
        rd_expect(3'd1, 32'h1, "R5 re-armed");
        wr(3'd1, 32'h1);

        // R7 press on the same edge as a clear of the SCI copy
        @(negedge clk); #1;
        pwrbtn_n = 0; bus_we = 1; bus_addr = 3'd1; bus_wdata = 32'h2;
        drive(1'b0, 3'd1, '0);
        rd_expect(3'd1, 32'h6, "R7 set wins");
        btn(1); idle(1);

        wr(3'd2, 32'h0);                        // R6 enables off
        rd_expect(3'd1, 32'h6, "R6 flags kept");
        check("R6 gated off", {30'h0, sci_req, smi_req}, 32'h0);
        wr(3'd2, 32'h4);
        check("R6 sci on", {30'h0, sci_req, smi_req}, 32'h2);

        // R8 / R9 reset port
        wr(3'd3, 32'h06); wr(3'd3, 32'h0E);
        wr(3'd3, 32'h07); wr(3'd3, 32'h16); wr(3'd3, 32'h0);
        wr(3'd0, 32'h1);
        wr(3'd3, 32'hFFFF_FF06); wr(3'd3, 32'h0E); wr(3'd3, 32'h0F);
        drive(1'b1, 3'd3, 32'h06); drive(1'b1, 3'd3, 32'h0E); drive(1'b0, 3'd3, 0);
        idle(2);

        // R11 reserved bits
        wr(3'd1, 32'hFFFF_FFF8);
        rd_expect(3'd1, 32'h6, "R11 status reserved");
        wr(3'd0, 32'hFFFF_FFFE);
        rd_expect(3'd0, 32'h0, "R11 policy reserved");
        wr(3'd5, 32'hFFFF_FFFF);
        rd_expect(3'd5, 32'h0, "R11 unused address");
        rd_expect(3'd3, 32'h0, "R11 reset port reads 0");
        idle(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule